// File: doc/BRIEF.md
# Bidirectional Port with Change Detection

An 8-bit general-purpose port. Each pin has a data latch bit and a direction bit. Pins whose direction bit selects input drive nothing; the rest drive their latch value. The upper half of the port has weak pull-ups that software can switch on as a group. All pin inputs pass through a two-stage synchroniser before any logic uses them.

The upper four pins also detect changes. The block takes a snapshot of the synchronised inputs on every read or write of the port register. Any upper pin that is an input and differs from its snapshot raises the change condition. This condition drives a wake request straight away and sets a sticky flag. The flag stays set for as long as the mismatch lasts, so software must first access the port and then clear the flag.

Software uses a single-cycle register bus. A write takes effect at the clock edge of the select cycle. Read data is combinational from the address.

Top module: `gpio_chg_port`

## Requirements
- R1: Direction register (address 1, reset 0xFF): bit value 1 makes a pin an input with `pad_oe_o` low. Bit value 0 drives the data latch (address 0 write, reset 0x00) on `pad_o` with `pad_oe_o` high. Direction changes appear on `pad_oe_o` one edge after the write.
- R2: Only pins 7 to 4 whose direction bit is 1 take part in change detection. Changes on pins 3 to 0, or on output pins, never raise `wake_o` or the flag.
- R3: A read of address 0 returns the pin inputs after a two-flop synchroniser. A pad change shows in read data after two clock edges and not after one.
- R4: Every read or write of address 0 stores the synchronised upper inputs as the reference. `wake_o` is high in any cycle in which an eligible synchronised input differs from that reference, which is two edges after a pad change.
- R5: The change flag (control register, address 2, bit 0) is set at the edge after any cycle with a mismatch, and set again on every such cycle. A write of 0 to bit 0 clears it only in a cycle with no mismatch, because a set wins over a clear.
- R6: An access to address 0 ends the mismatch. If the inputs are stable, `wake_o` is low in the cycle after the access.
- R7: `irq_o` is high exactly when the flag is set and the interrupt enable (control bit 1) is 1.
- R8: `pad_pu_o` bits 7 to 4 are high only when the pin is an input and the pull-up disable bit (control bit 7, active high, reset 1) is 0. `pad_pu_o` bits 3 to 0 are always 0.
- R9: Writing 1 to flag bit 0 has no effect. Control bits 6 to 2 read as 0. Address 3 reads as 0.
- R10: After reset, the control register reads 0x80, the direction register reads 0xFF, and `irq_o`, `wake_o`, `pad_oe_o` and `pad_pu_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 port, 1 direction, 2 control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| pad_i | input | 8 | Pin input levels |
| pad_o | output | 8 | Pin output levels |
| pad_oe_o | output | 8 | Output driver enable per pin |
| pad_pu_o | output | 8 | Weak pull-up enable per pin |
| irq_o | output | 1 | Level change interrupt |
| wake_o | output | 1 | Raw change condition used as a wake request |

## Verification
The hardest case to reach is a clear that fails because the mismatch is still live. To reach it, the bench first moves an upper input pin and waits for `wake_o`. It then writes 0 to the flag bit without touching the port, and checks that the flag reads back as 1. Only then does it access the port and repeat the clear. The same approach checks output pins: the bench drives an upper pin from the data latch, so the pin level changes, and confirms that no mismatch is reported.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_FLAG_BIT = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_chg_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              set_flag_i,
  output logic [PORT_W-1:0] data_o,
  output logic [PORT_W-1:0] dir_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic              pudis_o
);
  localparam int unsigned PUDIS_BIT = PORT_W - 1;

  logic [PORT_W-1:0] data_q, dir_q;
  logic              flag_q, ie_q, pudis_q;
  logic              wr_data, wr_dir, wr_ctrl;
  logic              unused_wbits;

  assign wr_data = wr_i && (addr_i == REG_PORT);
  assign wr_dir  = wr_i && (addr_i == REG_DIR);
  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign unused_wbits = ^wdata_i[PUDIS_BIT-1:CTRL_IE_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dir_q   <= '1;
      ie_q    <= 1'b0;
      pudis_q <= 1'b1;
    end else begin
      if (wr_data) data_q <= wdata_i;
      if (wr_dir)  dir_q  <= wdata_i;
      if (wr_ctrl) begin
        ie_q    <= wdata_i[CTRL_IE_BIT];
        pudis_q <= wdata_i[PUDIS_BIT];
      end
    end
  end

  // set has priority over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   flag_q <= 1'b0;
    else if (set_flag_i)                           flag_q <= 1'b1;
    else if (wr_ctrl && !wdata_i[CTRL_FLAG_BIT])   flag_q <= 1'b0;
  end

  assign data_o  = data_q;
  assign dir_o   = dir_q;
  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign pudis_o = pudis_q;
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int unsigned NCHG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCHG-1:0] in_i,
  input  logic [NCHG-1:0] is_in_i,
  input  logic            access_i,
  output logic [NCHG-1:0] mism_o,
  output logic            chg_o
);
  logic [NCHG-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       snap_q <= '0;
    else if (access_i) snap_q <= in_i;
  end

  assign mism_o = (in_i ^ snap_q) & is_in_i;
  assign chg_o  = |mism_o;
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned CHG_LSB = 4
) (
  input  logic [PORT_W-1:0] data_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              pudis_i,
  output logic [PORT_W-1:0] pad_o,
  output logic [PORT_W-1:0] pad_oe_o,
  output logic [PORT_W-1:0] pad_pu_o
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign pad_oe_o[i] = ~dir_i[i];
    assign pad_o[i]    = data_i[i];
    if (i >= CHG_LSB) begin : g_pu
      assign pad_pu_o[i] = dir_i[i] & ~pudis_i;
    end else begin : g_nopu
      assign pad_pu_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned CHG_LSB     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [PORT_W-1:0] bus_wdata_i,
  output logic [PORT_W-1:0] bus_rdata_o,
  input  logic [PORT_W-1:0] pad_i,
  output logic [PORT_W-1:0] pad_o,
  output logic [PORT_W-1:0] pad_oe_o,
  output logic [PORT_W-1:0] pad_pu_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned NCHG = PORT_W - CHG_LSB;

  logic [PORT_W-1:0] sync_q, data_q, dir_q;
  logic [NCHG-1:0]   mism;
  logic              flag_q, ie_q, pudis_q, chg, port_acc, wr;
  logic [PORT_W-1:0] ctrl_rd;

  assign wr       = bus_sel_i && bus_we_i;
  assign port_acc = bus_sel_i && (bus_addr_i == REG_PORT);

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(sync_q)
  );

  gpio_regs #(.PORT_W(PORT_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .set_flag_i(chg),
    .data_o(data_q), .dir_o(dir_q), .flag_o(flag_q),
    .ie_o(ie_q), .pudis_o(pudis_q)
  );

  gpio_chg_det #(.NCHG(NCHG)) det_i (
    .clk_i, .rst_ni,
    .in_i(sync_q[PORT_W-1:CHG_LSB]),
    .is_in_i(dir_q[PORT_W-1:CHG_LSB]),
    .access_i(port_acc),
    .mism_o(mism), .chg_o(chg)
  );

  gpio_pad_ctl #(.PORT_W(PORT_W), .CHG_LSB(CHG_LSB)) pad_i_ctl (
    .data_i(data_q), .dir_i(dir_q), .pudis_i(pudis_q),
    .pad_o, .pad_oe_o, .pad_pu_o
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_FLAG_BIT] = flag_q;
    ctrl_rd[CTRL_IE_BIT]   = ie_q;
    ctrl_rd[PORT_W-1]      = pudis_q;
  end

  always_comb begin
    unique case (bus_addr_i)
      REG_PORT: bus_rdata_o = sync_q;
      REG_DIR:  bus_rdata_o = dir_q;
      REG_CTRL: bus_rdata_o = ctrl_rd;
      default:  bus_rdata_o = '0;
    endcase
  end

  logic unused_mism;
  assign unused_mism = ^mism;

  assign wake_o = chg;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned CHG_LSB = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic [PORT_W-1:0] bus_wdata_i,
  input logic [PORT_W-1:0] pad_oe_o,
  input logic [PORT_W-1:0] pad_pu_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic              flag_q,
  input logic [PORT_W-1:0] sync_q,
  input logic [PORT_W-1:0] dir_q
);
  logic acc, dir_wr, ctrl_wr;
  assign acc     = bus_sel_i && (bus_addr_i == 2'd0);
  assign dir_wr  = bus_sel_i && bus_we_i && (bus_addr_i == 2'd1);
  assign ctrl_wr = bus_sel_i && bus_we_i && (bus_addr_i == 2'd2);

  assert_dir_to_oe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr |=> pad_oe_o == ~$past(bus_wdata_i));

  assert_wake_needs_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> |dir_q[PORT_W-1:CHG_LSB]);

  assert_flag_follows_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> flag_q);

  assert_access_ends_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (!wake_o || sync_q != $past(sync_q)));

  assert_irq_rise_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(wake_o) || $past(ctrl_wr)));

  assert_pu_inputs_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o & pad_oe_o) == '0) && (pad_pu_o[CHG_LSB-1:0] == '0));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.PORT_W(PORT_W), .CHG_LSB(CHG_LSB)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .pad_oe_o(pad_oe_o),
  .pad_pu_o(pad_pu_o), .irq_o(irq_o), .wake_o(wake_o), .flag_q(flag_q),
  .sync_q(sync_q), .dir_q(dir_q)
);

// File: tb/gpio_chg_port_tb_top.sv
module gpio_chg_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, pad_in, pad_out, pad_oe, pad_pu, ext;
  logic       irq, wake;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rd;

  always #4 clk_i = ~clk_i;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_chg_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
    .irq_o(irq), .wake_o(wake)
  );

  // fields: dir, data, ext
  localparam logic [23:0] VEC [0:5] = '{
    {8'hFF, 8'h00, 8'hA5}, {8'h00, 8'h5A, 8'h00}, {8'h0F, 8'hC3, 8'h3C},
    {8'hF0, 8'h99, 8'hFF}, {8'hAA, 8'h55, 8'h0F}, {8'h55, 8'hF0, 8'hC3}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_i);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk_i);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    ext = 8'h00;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R10 reset state
    bus_read(2'd2, rd); check("R10 ctrl reset", rd, 8'h80);
    bus_read(2'd1, rd); check("R10 dir reset", rd, 8'hFF);
    check("R10 irq/wake reset", {6'd0, irq, wake}, 8'h00);
    check("R10 oe reset", pad_oe, 8'h00);
    check("R10 pu reset", pad_pu, 8'h00);

    // vector table: R1 drive/direction, R3 read-back, R6 no residual mismatch
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d, x, t;
      t = VEC[v][23:16]; d = VEC[v][15:8]; x = VEC[v][7:0];
      bus_write(2'd1, t);
      bus_write(2'd0, d);
      ext = x;
      idle(3);
      bus_read(2'd0, rd);
      check("R3 port read", rd, (t & x) | (~t & d));
      check("R6 wake after read", {7'd0, wake}, 8'h00);
      check("R1 oe", pad_oe, ~t);
      check("R1 driven", pad_out & ~t, d & ~t);
    end

    // change detection setup
    bus_write(2'd1, 8'hFF);
    ext = 8'h00;
    idle(3);
    bus_read(2'd0, rd);
    bus_write(2'd2, 8'h02);
    check("R7 irq idle", {7'd0, irq}, 8'h00);

    ext = 8'h20;
    idle(1); check("R4 wake after 1 edge", {7'd0, wake}, 8'h00);
    idle(1); check("R4 wake after 2 edges", {7'd0, wake}, 8'h01);
    idle(1); check("R7 irq raised", {7'd0, irq}, 8'h01);

    bus_write(2'd2, 8'h02);
    bus_read(2'd2, rd); check("R5 clear loses to live mismatch", rd, 8'h03);

    bus_read(2'd0, rd);
    check("R6 read ends mismatch", {7'd0, wake}, 8'h00);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, rd); check("R5 clear after access", rd, 8'h02);
    check("R7 irq cleared", {7'd0, irq}, 8'h00);

    ext = 8'h24;
    idle(4);
    check("R2 lower pin no wake", {7'd0, wake}, 8'h00);
    bus_read(2'd2, rd); check("R2 lower pin no flag", rd, 8'h02);

    ext = 8'h04;
    idle(3);
    check("R4 mismatch back to ref", {7'd0, wake}, 8'h01);
    bus_write(2'd0, 8'h00);
    check("R6 write ends mismatch", {7'd0, wake}, 8'h00);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, rd); check("R5 cleared", rd, 8'h02);

    bus_write(2'd1, 8'h7F);
    bus_write(2'd0, 8'h80);
    idle(4);
    check("R2 output pin no wake", {7'd0, wake}, 8'h00);
    bus_read(2'd2, rd); check("R2 output pin no flag", rd, 8'h02);

    bus_write(2'd2, 8'h00);
    ext = 8'h44;
    idle(4);
    check("R7 wake with ie off", {7'd0, wake}, 8'h01);
    check("R7 irq masked", {7'd0, irq}, 8'h00);
    bus_read(2'd2, rd); check("R7 flag set while masked", rd, 8'h01);
    bus_write(2'd2, 8'h02);
    check("R7 irq on enable", {7'd0, irq}, 8'h01);

    bus_read(2'd0, rd);
    bus_write(2'd2, 8'h7E);
    bus_read(2'd2, rd); check("R9 reserved bits read 0", rd, 8'h02);
    bus_write(2'd2, 8'h03);
    bus_read(2'd2, rd); check("R9 write 1 to flag ignored", rd, 8'h02);
    bus_read(2'd3, rd); check("R9 addr 3 reads 0", rd, 8'h00);

    check("R8 pu dir 7F", pad_pu, 8'h70);
    bus_write(2'd1, 8'hF0);
    check("R8 pu dir F0", pad_pu, 8'hF0);
    bus_write(2'd1, 8'h0F);
    check("R8 pu upper outputs", pad_pu, 8'h00);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'h82);
    check("R8 pu disabled", pad_pu, 8'h00);

    ext = 8'h00;
    idle(3);
    bus_read(2'd0, rd);
    ext = 8'h11;
    idle(1);
    bus_read(2'd0, rd); check("R3 one edge old value", rd, 8'h00);
    bus_read(2'd0, rd); check("R3 two edges new value", rd, 8'h11);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule